// File: doc/BRIEF.md
# Receive Phase Compensation FIFO

This block sits at the hand-off between a serial-link receive datapath and user logic. Each parallel word arrives with a few status bits on the recovered parallel clock and leaves on the user-logic clock. Status bits are stored in the same entry as their word. The buffer holds eight entries.

The operating mode is picked by an input that is sampled only while reset is held. In low-latency mode the block is a dual-clock FIFO. Its empty and full limits are pulled close together, so only a few entries are ever in use and the delay from write to read stays short. Read and write positions cross between the two domains as Gray code through two-flop synchronizers. In register mode the storage is bypassed. The caller drives both clocks from one source, and each word shows up at the output exactly one clock after it was written.

A write attempted while the buffer is full, or a read attempted while it is empty, is discarded. Either one sets an error flag that stays set until reset.

Top module: `rx_phase_comp_fifo`

## Requirements
- R1: While reset is held and after it is released, `empty` is 1, `full` is 0 and `err` is 0. Reset clears both the write and read positions.
- R2: In low-latency mode, `empty` is 1 whenever fewer than 2 entries are occupied. Once a second entry has been written, `empty` falls within 20 read-clock cycles.
- R3: In low-latency mode, `full` is 0 while 5 or fewer entries are occupied. It is 1 in the write-clock cycle after the write that fills the sixth entry, and occupancy never goes above 6.
- R4: A write with `full` high, or a read with `empty` high, is discarded: no position moves and no word is stored. Either one sets `err`, which stays 1 until reset.
- R5: In low-latency mode, words leave in the order they were written. A read accepted on a read-clock edge (`rd_en` high, `empty` low) presents its word on `rd_data` after that same edge.
- R6: `rd_stat` always holds the status bits that were written together with the word on `rd_data`.
- R7: In register mode, after each write-clock edge where `wr_en` was high, `rd_data`/`rd_stat` equal the word and status written on that edge. `empty` equals the inverse of `wr_en` on that edge, and `full` stays 0.
- R8: In register mode, `rd_en` has no effect, and `err` stays 0.
- R9: `reg_mode` is sampled only while `rst` is high (1 selects register mode, 0 selects low-latency mode). Changing it outside reset does not change the behaviour.
- R10: The position carried across the clock domains changes by at most one bit per receiving-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered parallel clock (write side) |
| rd_clk | input | 1 | User-logic clock (read side); tied to wr_clk in register mode |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| reg_mode | input | 1 | Mode select sampled in reset: 1 register mode, 0 low-latency |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Incoming word |
| wr_stat | input | STAT_W | Status bits for the incoming word |
| rd_en | input | 1 | Read request (low-latency mode only) |
| rd_data | output | DATA_W | Outgoing word |
| rd_stat | output | STAT_W | Status bits of the outgoing word |
| empty | output | 1 | No word available for reading |
| full | output | 1 | No room for another write |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that reset is held long enough to cover several edges of both clocks, and that register mode is only used when the read clock is the write clock. The bench meets the first assumption by holding reset across six edges of each clock. It meets the second by switching the read clock onto the write clock only while reset is high. The assertions also rely on the positions being carried across domains as Gray code, which is checked as a property in its own right. Between resets, the bench toggles `reg_mode` only in the directed test that shows the change is ignored.

// File: rtl/rxpc_pkg.sv
package rxpc_pkg;
  typedef enum logic {
    MODE_LOWLAT   = 1'b0,
    MODE_REGSTAGE = 1'b1
  } rxpc_mode_e;
endpackage

// File: rtl/rxpc_sync.sv
module rxpc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rxpc_ram.sv
module rxpc_ram #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  // registered read port, synchronous reset on the output register only
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/rxpc_wr_ctl.sv
module rxpc_wr_ctl #(
  parameter int PW       = 4,
  parameter int FULL_LVL = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wgray,
  output logic [PW-2:0] waddr,
  output logic          we,
  output logic          full,
  output logic          ovf
);
  localparam logic [PW-1:0] FULL_V = PW'(FULL_LVL);

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, used_nxt;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign we       = en && wr_en && !full;
  assign wbin_nxt = wbin + PW'(we);
  assign used_nxt = wbin_nxt - rbin_s;
  assign waddr    = wbin[PW-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      full  <= (used_nxt >= FULL_V);
      if (en && wr_en && full) ovf <= 1'b1;
    end
  end

  // R4: a write presented while full leaves the write position where it was
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (en && wr_en && full) |=> $stable(wbin));

  // R3: occupancy seen from the write side never passes the full level
  assert_occupancy_cap_R3: assert property (@(posedge clk) disable iff (rst)
    ((wbin - rbin_s) <= FULL_V));

  // R4: the overflow flag, once set, stays set until reset
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: rtl/rxpc_rd_ctl.sv
module rxpc_rd_ctl #(
  parameter int PW        = 4,
  parameter int EMPTY_LVL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rgray,
  output logic [PW-2:0] raddr,
  output logic          re,
  output logic          empty,
  output logic          udf
);
  localparam logic [PW-1:0] EMPTY_V = PW'(EMPTY_LVL);

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, avail_nxt;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign re        = en && rd_en && !empty;
  assign rbin_nxt  = rbin + PW'(re);
  assign avail_nxt = wbin_s - rbin_nxt;
  assign raddr     = rbin[PW-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
      udf   <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      empty <= (avail_nxt < EMPTY_V);
      if (en && rd_en && empty) udf <= 1'b1;
    end
  end

  // R4: a read presented while empty leaves the read position where it was
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (en && rd_en && empty) |=> $stable(rbin));

  // R10: the synchronized write position moves by at most one bit per cycle
  assert_gray_step_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(wgray_s ^ $past(wgray_s)) <= 1));
endmodule

// File: rtl/rx_phase_comp_fifo.sv
module rx_phase_comp_fifo
  import rxpc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STAT_W    = 2,
  parameter int DEPTH     = 8,
  parameter int EMPTY_LVL = 2,
  parameter int FULL_LVL  = 6
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              reg_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic              empty,
  output logic              full,
  output logic              err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int EW = DATA_W + STAT_W;

  rxpc_mode_e mode_w, mode_r;

  // mode is latched in each domain only while reset is held
  always_ff @(posedge wr_clk) if (rst) mode_w <= rxpc_mode_e'(reg_mode);
  always_ff @(posedge rd_clk) if (rst) mode_r <= rxpc_mode_e'(reg_mode);

  logic          fifo_w_en, fifo_r_en;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we, re, ll_full, ll_empty, ovf, udf, ovf_s;
  logic [EW-1:0] mem_q, byp_q;
  logic          byp_vld, err_q;

  assign fifo_w_en = (mode_w == MODE_LOWLAT);
  assign fifo_r_en = (mode_r == MODE_LOWLAT);

  rxpc_wr_ctl #(.PW(PW), .FULL_LVL(FULL_LVL)) u_wr (
    .clk(wr_clk), .rst(rst), .en(fifo_w_en), .wr_en(wr_en),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .we(we),
    .full(ll_full), .ovf(ovf)
  );

  rxpc_rd_ctl #(.PW(PW), .EMPTY_LVL(EMPTY_LVL)) u_rd (
    .clk(rd_clk), .rst(rst), .en(fifo_r_en), .rd_en(rd_en),
    .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr), .re(re),
    .empty(ll_empty), .udf(udf)
  );

  rxpc_sync #(.W(PW)) u_sync_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));
  rxpc_sync #(.W(PW)) u_sync_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));
  rxpc_sync #(.W(1))  u_sync_err (.clk(rd_clk), .rst(rst), .d(ovf),   .q(ovf_s));

  rxpc_ram #(.W(EW), .DEPTH(DEPTH)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata({wr_stat, wr_data}),
    .rclk(rd_clk), .rrst(rst), .re(re), .raddr(raddr), .rdata(mem_q)
  );

  // single register stage used in register mode
  always_ff @(posedge wr_clk) begin
    if (rst) begin
      byp_vld <= 1'b0;
      byp_q   <= '0;
    end else begin
      byp_vld <= wr_en;
      if (wr_en) byp_q <= {wr_stat, wr_data};
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rst)              err_q <= 1'b0;
    else if (udf | ovf_s) err_q <= 1'b1;
  end

  assign {rd_stat, rd_data} = (mode_r == MODE_REGSTAGE) ? byp_q : mem_q;
  assign empty = (mode_r == MODE_REGSTAGE) ? !byp_vld : ll_empty;
  assign full  = (mode_w == MODE_REGSTAGE) ? 1'b0 : ll_full;
  assign err   = err_q;

  // R7: in register mode the written word is on the output one edge later
  assert_regstage_latency_R7: assert property (@(posedge wr_clk) disable iff (rst)
    ((mode_w == MODE_REGSTAGE) && wr_en) |=> ({rd_stat, rd_data} == $past({wr_stat, wr_data})));

  // R8: register mode never raises the error flag
  assert_regstage_no_err_R8: assert property (@(posedge wr_clk) disable iff (rst)
    ((mode_w == MODE_REGSTAGE) && (mode_r == MODE_REGSTAGE)) |-> !err);
endmodule

// File: tb/tb_rx_phase_comp_fifo.sv
`timescale 1ns/1ps
module tb_rx_phase_comp_fifo;
  localparam int  DATA_W     = 16;
  localparam int  STAT_W     = 2;
  localparam real CLK_PERIOD = 10.0;
  localparam real RD_PERIOD  = 15.0;

  // register-mode vectors: {wr_en, stat[1:0], data[15:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 2'd1, 16'h1234}, {1'b1, 2'd2, 16'hBEEF}, {1'b0, 2'd3, 16'h0F0F},
    {1'b1, 2'd3, 16'h00FF}, {1'b0, 2'd0, 16'hFFFF}, {1'b0, 2'd1, 16'h5555},
    {1'b1, 2'd0, 16'hAAAA}, {1'b1, 2'd2, 16'h8001}
  };

  logic wr_clk = 0, rd_free = 0, tie_clk = 0, rd_clk;
  logic rst = 1, reg_mode = 0, wr_en = 0, rd_en = 0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [STAT_W-1:0] wr_stat = '0, rd_stat;
  logic empty, full, err;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_free = ~rd_free;
  assign rd_clk = tie_clk ? wr_clk : rd_free;

  rx_phase_comp_fifo #(.DATA_W(DATA_W), .STAT_W(STAT_W)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .reg_mode(reg_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat), .rd_en(rd_en),
    .rd_data(rd_data), .rd_stat(rd_stat), .empty(empty), .full(full), .err(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input int i);
    return DATA_W'(16'hA500 + i);
  endfunction

  task automatic do_reset(input logic mode);
    rst = 1; wr_en = 0; rd_en = 0; reg_mode = mode;
    tie_clk = mode;
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    check(empty == 1 && full == 0 && err == 0, "R1 in reset", {empty, full, err}, 3'b100);
    @(negedge wr_clk) rst = 0;
    repeat (2) @(negedge rd_clk);
    check(empty == 1 && full == 0 && err == 0, "R1 after reset", {empty, full, err}, 3'b100);
  endtask

  task automatic put(input logic [DATA_W-1:0] d, input logic [STAT_W-1:0] s);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d; wr_stat = s;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic take(input string req, input logic [DATA_W-1:0] ed, input logic [STAT_W-1:0] es);
    int n = 0;
    @(negedge rd_clk);
    while (empty && n < 20) begin @(negedge rd_clk); n++; end
    check(!empty, {req, " data ready"}, 32'(empty), 32'd0);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_data == ed, {req, " data"}, 32'(rd_data), 32'(ed));
    check(rd_stat == es, "R6 status with word", 32'(rd_stat), 32'(es));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DATA_W+STAT_W-1:0] last;

    // ---------- register mode: vector table ----------
    do_reset(1'b1);
    last = '0;
    @(negedge wr_clk);
    for (int i = 0; i < 8; i++) begin
      wr_en = VEC[i][18]; wr_stat = VEC[i][17:16]; wr_data = VEC[i][15:0];
      rd_en = i[0];
      @(negedge wr_clk);
      if (VEC[i][18]) last = VEC[i][17:0];
      check({rd_stat, rd_data} == last, "R7 register-mode output", 32'({rd_stat, rd_data}), 32'(last));
      check(empty == !VEC[i][18], "R7 register-mode empty", 32'(empty), 32'(!VEC[i][18]));
      check(full == 0, "R7 register-mode full", 32'(full), 32'd0);
    end
    wr_en = 0; rd_en = 0;
    @(negedge wr_clk);
    check(err == 0, "R8 rd_en ignored, no error", 32'(err), 32'd0);

    // R9: flip mode select outside reset; behaviour must stay register mode
    reg_mode = 0;
    @(negedge wr_clk);
    wr_en = 1; wr_data = 16'h7E57; wr_stat = 2'd2;
    @(negedge wr_clk);
    wr_en = 0;
    check(rd_data == 16'h7E57 && empty == 0, "R9 mode held outside reset", 32'({empty, rd_data}), 32'h7E57);

    // ---------- low-latency: empty threshold ----------
    do_reset(1'b0);
    put(word(0), 2'd1);
    repeat (20) @(negedge rd_clk);
    check(empty == 1, "R2 one entry still empty", 32'(empty), 32'd1);
    put(word(1), 2'd2);
    take("R5 first word", word(0), 2'd1);
    check(empty == 1, "R2 back below threshold", 32'(empty), 32'd1);

    // ---------- low-latency: full threshold, overflow, ordering ----------
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) begin
      put(word(i), STAT_W'(i));
      check(full == 0, "R3 five or fewer not full", 32'(full), 32'd0);
    end
    put(word(5), 2'd1);
    check(full == 1, "R3 full at six", 32'(full), 32'd1);
    put(word(6), 2'd2);                    // dropped
    repeat (8) @(negedge rd_clk);
    check(err == 1, "R4 overflow sets err", 32'(err), 32'd1);
    for (int i = 0; i < 5; i++) take("R5 order", word(i), STAT_W'(i));
    put(word(7), 2'd3);
    take("R5 order", word(5), 2'd1);
    put(word(8), 2'd0);
    take("R4 dropped word absent", word(7), 2'd3);
    check(err == 1, "R4 err sticky", 32'(err), 32'd1);

    // ---------- low-latency: underflow ----------
    do_reset(1'b0);
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    repeat (3) @(negedge rd_clk);
    check(err == 1, "R4 underflow sets err", 32'(err), 32'd1);
    check(empty == 1 && rd_data == 0, "R4 underflow read dropped", 32'({empty, rd_data}), 32'h10000);
    do_reset(1'b0);
    check(err == 0, "R1 reset clears err", 32'(err), 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule